// File: doc/BRIEF.md
# Card Management Register File

This block holds the control registers that a flash memory card exposes in its attribute space, at even byte addresses from 4000h. A host reaches them through a byte-wide port that carries an address, write data, a write strobe and a combinational read-data path. The registers drive the card-wide soft-reset line, a deep power-down line for each device pair, the block-locking enable and two write-protect lines. A read-only status byte gathers the state of these registers together with the external write-protect switch, the OR of the ready/busy mask bits and the all-devices-ready flag.

Soft reset is handled by a two-state controller. In `ST_RUN` the registers take host writes. The transition `RUN->HOLD` happens when a write to the configuration-option register carries bit 7 set. In `ST_HOLD` the card-reset output is high. On the same edge the power-down, protection and sleep registers are cleared, and they stay cleared. The transition `HOLD->RUN` happens when a write to the configuration-option register carries bit 7 clear. The socket/copy register is not affected by soft reset.

Top module: `cmr_regfile`

## Requirements
- R1: After the active-low reset `rst_n`, every register is zero: all mapped addresses read back 00h except the status byte, which shows only its live inputs, and all control outputs are low.
- R2: A write to 4000h with bit 7 set makes `card_reset` high from the next cycle, and 4000h then reads 80h. A write to 4000h with bit 7 clear returns `card_reset` low. The other bits of 4000h read 0.
- R3: On entry to soft reset, the power-down bit, the protection register and all sleep bits are cleared on the same edge. While soft reset lasts, writes to them are ignored.
- R4: At 4002h, bit 2 holds the global power-down bit. The other bits of 4002h read 0.
- R5: At 4006h, all 8 bits are writable: the socket number is in bits 7..4 and the copy number in bits 3..0. The value is kept through soft reset.
- R6: At 4104h, bit 2 drives `blk_lock_en`, bit 1 drives `cm_wp` and bit 0 drives `cis_wp`. Bits 7..3 read 0.
- R7: At 4118h, bits 0..2 are the sleep selects for pairs 0, 1 and 2. At 411Ah, bits 0..2 are the sleep selects for pairs 3, 4 and 5. Bits 7..3 of both read 0.
- R8: `pair_pwdn[i]` is high exactly when the global power-down bit and the sleep bit of pair i are both 1.
- R9: 4100h is read-only. Its bits, from 7 down to 0, are: `any_masked`, the OR of all sleep bits, soft reset, common-memory write protect, power-down, information-area write protect, `wp_switch` and `all_ready`.
- R10: Odd addresses and unmapped even addresses read 00h, and writes to them change nothing.
- R11: Writes to this register region take effect whatever the level of `wp_switch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| att_addr | input | 15 | Attribute byte address |
| att_wdata | input | 8 | Write data |
| att_we | input | 1 | Write strobe, one write per cycle while high |
| att_rdata | output | 8 | Read data for `att_addr` (combinational) |
| wp_switch | input | 1 | Write-protect switch level |
| any_masked | input | 1 | OR of the ready/busy mask bits |
| all_ready | input | 1 | All devices ready |
| card_reset | output | 1 | Soft-reset hold |
| pair_pwdn | output | 6 | Deep power-down, one bit per device pair |
| blk_lock_en | output | 1 | Block locking enable |
| cm_wp | output | 1 | Common-memory write protect |
| cis_wp | output | 1 | Information-area write protect |

## Verification
On every cycle the assertions check three things. First, the soft-reset controller enters and leaves `ST_HOLD` only through writes to 4000h. Second, the cleared registers and their outputs stay quiet while the hold lasts. Third, the socket/copy register, the sleep registers and the other registers do not change without a write that selects them; this includes writes to odd addresses, unmapped addresses and the status byte. The bench scenarios show the rest: the bit position of each field in the read data, the layout of the composite status byte under changing inputs, the per-pair power-down gating, and the survival of the socket/copy value through soft reset. The bench checks these against a register model after random mixes of writes.

// File: rtl/cmr_pkg.sv
package cmr_pkg;
    localparam int CMR_AW = 15;

    localparam logic [CMR_AW-1:0] A_COR      = 15'h4000;
    localparam logic [CMR_AW-1:0] A_CCR      = 15'h4002;
    localparam logic [CMR_AW-1:0] A_SCR      = 15'h4006;
    localparam logic [CMR_AW-1:0] A_CSR      = 15'h4100;
    localparam logic [CMR_AW-1:0] A_WPR      = 15'h4104;
    localparam logic [CMR_AW-1:0] A_SLP_BASE = 15'h4118;

    localparam int SEL_COR = 0;
    localparam int SEL_CCR = 1;
    localparam int SEL_SCR = 2;
    localparam int SEL_CSR = 3;
    localparam int SEL_WPR = 4;
    localparam int SEL_SLP = 5;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } srst_state_e;
endpackage

// File: rtl/cmr_decode.sv
module cmr_decode
    import cmr_pkg::*;
#(
    parameter int ADDR_W  = 15,
    parameter int NUM_SLP = 2,
    localparam int NSEL   = SEL_SLP + NUM_SLP
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NSEL-1:0]   sel
);
    always_comb begin
        sel          = '0;
        sel[SEL_COR] = (addr == ADDR_W'(A_COR));
        sel[SEL_CCR] = (addr == ADDR_W'(A_CCR));
        sel[SEL_SCR] = (addr == ADDR_W'(A_SCR));
        sel[SEL_CSR] = (addr == ADDR_W'(A_CSR));
        sel[SEL_WPR] = (addr == ADDR_W'(A_WPR));
        for (int k = 0; k < NUM_SLP; k++) begin
            sel[SEL_SLP+k] = (addr == ADDR_W'(A_SLP_BASE) + ADDR_W'(2 * k));
        end
    end
endmodule

// File: rtl/cmr_srst_fsm.sv
module cmr_srst_fsm
    import cmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cor_we,
    input  logic set_bit,
    output logic hold,
    output logic clr
);
    srst_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (cor_we && set_bit)  state_d = ST_HOLD;
            ST_HOLD: if (cor_we && !set_bit) state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        hold = (state_q == ST_HOLD);
        clr  = (state_d == ST_HOLD);
    end

    // R2: the hold is left only by a write with bit 7 clear
    a_r2_hold_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !(cor_we && !set_bit)) |=> (state_q == ST_HOLD));
    // R2: the hold is entered only by a write with bit 7 set
    a_r2_enter_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !(cor_we && set_bit)) |=> (state_q == ST_RUN));
endmodule

// File: rtl/cmr_sleep_reg.sv
module cmr_sleep_reg #(
    parameter int BITS = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            we,
    input  logic [BITS-1:0] d,
    output logic [BITS-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else if (we)  q <= d;
    end

    // R7: sleep selects move only on a write to their own address
    a_r7_sleep_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && !clr) |=> $stable(q));
    // R3: soft reset leaves the selects cleared
    a_r3_sleep_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));
endmodule

// File: rtl/cmr_regfile.sv
module cmr_regfile
    import cmr_pkg::*;
#(
    parameter int ADDR_W        = 15,
    parameter int NUM_PAIRS     = 6,
    parameter int PAIRS_PER_REG = 3,
    localparam int NUM_SLP      = NUM_PAIRS / PAIRS_PER_REG,
    localparam int NSEL         = SEL_SLP + NUM_SLP
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    att_addr,
    input  logic [7:0]           att_wdata,
    input  logic                 att_we,
    output logic [7:0]           att_rdata,
    input  logic                 wp_switch,
    input  logic                 any_masked,
    input  logic                 all_ready,
    output logic                 card_reset,
    output logic [NUM_PAIRS-1:0] pair_pwdn,
    output logic                 blk_lock_en,
    output logic                 cm_wp,
    output logic                 cis_wp
);
    logic [NSEL-1:0]      sel;
    logic                 hold, clr;
    logic                 pwdn_q;
    logic [7:0]           scr_q;
    logic [2:0]           wpr_q;
    logic [NUM_PAIRS-1:0] sleep_q;

    cmr_decode #(.ADDR_W(ADDR_W), .NUM_SLP(NUM_SLP)) u_dec (
        .addr (att_addr),
        .sel  (sel)
    );

    cmr_srst_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cor_we  (att_we && sel[SEL_COR]),
        .set_bit (att_wdata[7]),
        .hold    (hold),
        .clr     (clr)
    );

    for (genvar k = 0; k < NUM_SLP; k++) begin : g_slp
        cmr_sleep_reg #(.BITS(PAIRS_PER_REG)) u_slp (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .we    (att_we && sel[SEL_SLP+k]),
            .d     (att_wdata[PAIRS_PER_REG-1:0]),
            .q     (sleep_q[k*PAIRS_PER_REG +: PAIRS_PER_REG])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwdn_q <= 1'b0;
            wpr_q  <= '0;
        end else if (clr) begin
            pwdn_q <= 1'b0;
            wpr_q  <= '0;
        end else if (att_we) begin
            if (sel[SEL_CCR]) pwdn_q <= att_wdata[2];
            if (sel[SEL_WPR]) wpr_q  <= att_wdata[2:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      scr_q <= '0;
        else if (att_we && sel[SEL_SCR]) scr_q <= att_wdata;
    end

    always_comb begin
        att_rdata = 8'h00;
        if (sel[SEL_COR]) att_rdata = {hold, 7'b0};
        if (sel[SEL_CCR]) att_rdata = {5'b0, pwdn_q, 2'b0};
        if (sel[SEL_SCR]) att_rdata = scr_q;
        if (sel[SEL_CSR]) att_rdata = {any_masked, |sleep_q, hold, wpr_q[1],
                                       pwdn_q, wpr_q[0], wp_switch, all_ready};
        if (sel[SEL_WPR]) att_rdata = {5'b0, wpr_q};
        for (int k = 0; k < NUM_SLP; k++) begin
            if (sel[SEL_SLP+k]) att_rdata = 8'(sleep_q[k*PAIRS_PER_REG +: PAIRS_PER_REG]);
        end
    end

    always_comb begin
        card_reset  = hold;
        pair_pwdn   = {NUM_PAIRS{pwdn_q}} & sleep_q;
        blk_lock_en = wpr_q[2];
        cm_wp       = wpr_q[1];
        cis_wp      = wpr_q[0];
    end

    // R2: a write of bit 7 to the option register raises the reset line next cycle
    a_r2_reset_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (att_we && sel[SEL_COR] && att_wdata[7]) |=> card_reset);
    // R3: nothing controlled by the cleared registers is active during the hold
    a_r3_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        card_reset |-> (pair_pwdn == '0 && !blk_lock_en && !cm_wp && !cis_wp));
    // R5: socket/copy value changes only on its own write, soft reset included
    a_r5_scr_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !(att_we && sel[SEL_SCR]) |=> $stable(scr_q));
    // R8: a pair powers down only while the global bit is set
    a_r8_pair_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (|pair_pwdn) |-> pwdn_q);
    // R10: writes outside the map leave all state unchanged
    a_r10_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (att_we && sel == '0) |=> $stable({hold, pwdn_q, scr_q, wpr_q, sleep_q}));
    // R9: the status byte is not writable
    a_r9_csr_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (att_we && sel[SEL_CSR]) |=> $stable({hold, pwdn_q, scr_q, wpr_q, sleep_q}));
endmodule

// File: tb/test_cmr_regfile.sv
`timescale 1ns/1ps
module test_cmr_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] att_addr = '0;
    logic [7:0]  att_wdata = '0;
    logic        att_we = 1'b0;
    logic [7:0]  att_rdata;
    logic        wp_switch = 1'b0, any_masked = 1'b0, all_ready = 1'b0;
    logic        card_reset, blk_lock_en, cm_wp, cis_wp;
    logic [5:0]  pair_pwdn;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic       m_hold, m_pwdn;
    logic [7:0] m_scr;
    logic [2:0] m_wpr;
    logic [5:0] m_slp;

    always #2.5 clk = ~clk;

    cmr_regfile i_cmr_regfile (
        .clk(clk), .rst_n(rst_n), .att_addr(att_addr), .att_wdata(att_wdata),
        .att_we(att_we), .att_rdata(att_rdata), .wp_switch(wp_switch),
        .any_masked(any_masked), .all_ready(all_ready), .card_reset(card_reset),
        .pair_pwdn(pair_pwdn), .blk_lock_en(blk_lock_en), .cm_wp(cm_wp), .cis_wp(cis_wp)
    );

    function automatic logic [14:0] addr_of(int i);
        case (i)
            0: return 15'h4000;  1: return 15'h4001;  2: return 15'h4002;
            3: return 15'h4006;  4: return 15'h4100;  5: return 15'h4104;
            6: return 15'h4118;  7: return 15'h411A;  8: return 15'h411C;
            default: return 15'h0004;
        endcase
    endfunction

    function automatic logic [7:0] exp_read(logic [14:0] a);
        case (a)
            15'h4000: return {m_hold, 7'b0};
            15'h4002: return {5'b0, m_pwdn, 2'b0};
            15'h4006: return m_scr;
            15'h4100: return {any_masked, |m_slp, m_hold, m_wpr[1], m_pwdn, m_wpr[0],
                              wp_switch, all_ready};
            15'h4104: return {5'b0, m_wpr};
            15'h4118: return {5'b0, m_slp[2:0]};
            15'h411A: return {5'b0, m_slp[5:3]};
            default:  return 8'h00;
        endcase
    endfunction

    task automatic model_write(logic [14:0] a, logic [7:0] d);
        if (a == 15'h4000) begin
            m_hold = d[7];
            if (m_hold) begin m_pwdn = 0; m_wpr = 0; m_slp = 0; end
        end else if (a == 15'h4006) begin
            m_scr = d;
        end else if (!m_hold) begin
            case (a)
                15'h4002: m_pwdn = d[2];
                15'h4104: m_wpr = d[2:0];
                15'h4118: m_slp[2:0] = d[2:0];
                15'h411A: m_slp[5:3] = d[2:0];
                default: ;
            endcase
        end
    endtask

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [14:0] a, logic [7:0] d);
        @(negedge clk);
        att_addr = a; att_wdata = d; att_we = 1'b1;
        @(negedge clk);
        att_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd_check(string req, logic [14:0] a);
        att_addr = a;
        #0.1;
        check(req, {1'b0, a}, {1'b0, a});
        checks--;
        check(req, {8'h00, att_rdata}, {8'h00, exp_read(a)});
    endtask

    task automatic check_outputs(string req);
        check(req, {7'b0, card_reset, blk_lock_en, cm_wp, cis_wp, 5'b0},
                   {7'b0, m_hold, m_wpr[2], m_wpr[1], m_wpr[0], 5'b0});
        check({req, " R8"}, {10'b0, pair_pwdn}, {10'b0, {6{m_pwdn}} & m_slp});
    endtask

    task automatic check_all(string req);
        for (int i = 0; i < 10; i++) rd_check(req, addr_of(i));
        check_outputs(req);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        m_hold = 0; m_pwdn = 0; m_scr = 0; m_wpr = 0; m_slp = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R4 / R7 / R8: power-down gating per pair
        wr(15'h4118, 8'hFD); wr(15'h411A, 8'h04);
        check_outputs("R7");
        wr(15'h4002, 8'hFF);
        check_all("R4");
        check_outputs("R8");
        // R11: writes with the switch on
        wp_switch = 1'b1;
        wr(15'h4104, 8'hFF);
        check_all("R11");
        check_outputs("R6");
        // R5
        wr(15'h4006, 8'h3C);
        rd_check("R5", 15'h4006);
        // R9: status write ignored, live inputs seen
        any_masked = 1'b1; all_ready = 1'b1;
        wr(15'h4100, 8'h00);
        check_all("R9");
        // R10: odd and unmapped
        wr(15'h4003, 8'h00); wr(15'h411C, 8'hFF); wr(15'h4001, 8'hFF);
        check_all("R10");
        // R2 / R3: soft reset
        wr(15'h4000, 8'h80);
        check_all("R2");
        check_outputs("R3");
        wr(15'h4104, 8'h07); wr(15'h4002, 8'h04); wr(15'h4118, 8'h07);
        check_all("R3");
        rd_check("R5", 15'h4006);
        wr(15'h4006, 8'hA5);
        rd_check("R5", 15'h4006);
        wr(15'h4000, 8'h7F);
        check_all("R2");

        for (int n = 0; n < 400; n++) begin
            wp_switch  = 1'($urandom);
            any_masked = 1'($urandom);
            all_ready  = 1'($urandom);
            if ($urandom % 8 == 0) wr(15'h4000, {1'($urandom % 4 == 0), 7'($urandom)});
            else wr(addr_of($urandom % 10), 8'($urandom));
            check_all("R9");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule